// File: doc/BRIEF.md
# Channel Rotation Sequencer for a Five-Channel Interleaved Converter

This block produces every digital routing control needed by a time-interleaved converter that has four regular channels and one spare. It runs from a single clock at the aggregate sample rate. It keeps a 100-position schedule, and over that schedule each of the five channels is taken offline in turn and fed a calibration tone. Meanwhile the remaining channels carry the signal.

Each cycle the block reports which channel the input routers send the tone to, and which channel the output multiplexer forwards. It also gives the per-channel sample strobes and a flag that marks the samples the skew estimator should use. Two pulses help the estimator: one when the schedule restarts, and one when a calibration window ends, so that the delay of the channel just measured can be updated. A low enable holds the whole schedule where it is.

Top module: `tirot_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, the schedule position is 0 and the outputs are: sched_start=1, cal_route=5'b00001, out_sel=4, samp_strobe=5'b10001, cal_valid=1, win_done=0.
- R2: The schedule position advances by one on each enabled cycle and wraps from 99 to 0. sched_start is high exactly when the position is 0.
- R3: cal_route is one-hot, and bit w is set for positions 20w to 20w+19 (w = 0..4, bit 4 being the spare), so the channels are calibrated in ascending order.
- R4: Strobe bit i of a regular channel (i = 0..3) is high exactly when position mod 4 equals i.
- R5: The spare's strobe, bit 4, is high exactly when position mod 5 equals 0.
- R6: out_sel is a binary channel index equal to position mod 4. The exception is when that index is the channel under calibration, in which case out_sel is 4 (the spare).
- R7: out_sel never names the channel whose cal_route bit is set.
- R8: cal_valid is high exactly when the strobe of the channel under calibration is high.
- R9: win_done is high exactly at positions 19, 39, 59, 79 and 99, which are the last cycles of the five windows.
- R10: While en is low, the position does not advance and every output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advances the schedule when high, holds it when low |
| cal_route | output | 5 | One-hot: channel that receives the calibration tone |
| out_sel | output | 3 | Channel index forwarded by the output multiplexer |
| samp_strobe | output | 5 | Per-channel sample strobes, bit 4 is the spare |
| cal_valid | output | 1 | Current sample is a calibration sample |
| sched_start | output | 1 | Schedule is at position 0 |
| win_done | output | 1 | Last cycle of a calibration window |

## Verification
The assertions assume that en is a clean level sampled on the clock and that reset is held for at least one edge. Under that assumption the only way the schedule can move is through enabled cycles. The stimulus changes en and reset only on the falling clock edge, and it mixes long enabled runs, which cross the 99-to-0 wrap and every window boundary, with irregular enable patterns, a frozen stretch, and a reset taken in the middle of the schedule. Expected outputs come from a position model kept in the bench.

// File: rtl/tirot_pkg.sv
package tirot_pkg;
  localparam int unsigned TIROT_DEF_CH = 4;

  // Number of clock cycles in one full rotation schedule.
  function automatic int unsigned sched_len(input int unsigned nch);
    return (nch + 1) * (nch + 1) * nch;
  endfunction
endpackage

// File: rtl/tirot_wrap_cnt.sv
module tirot_wrap_cnt #(
  parameter int unsigned LIMIT = 5,
  localparam int unsigned W = (LIMIT > 2) ? $clog2(LIMIT) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W-1:0] cnt_nxt;
  logic         at_top;

  assign at_top = (cnt == W'(LIMIT - 1));
  assign wrap   = step && at_top;

  always_comb begin
    cnt_nxt = cnt;
    if (step) begin
      if (at_top) cnt_nxt = '0;
      else        cnt_nxt = cnt + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/tirot_decode.sv
module tirot_decode #(
  parameter int unsigned NCH = 4,
  localparam int unsigned NTOT = NCH + 1,
  localparam int unsigned CW = (NCH > 2) ? $clog2(NCH) : 1,
  localparam int unsigned PW = $clog2(NTOT),
  localparam int unsigned TW = (NCH > 2) ? $clog2(NCH) : 1,
  localparam int unsigned WW = $clog2(NTOT)
) (
  input  logic [CW-1:0]   lane,
  input  logic [PW-1:0]   phase,
  input  logic [TW-1:0]   tone_in_win,
  input  logic [WW-1:0]   win,
  input  logic            pos_zero,
  output logic [NTOT-1:0] cal_route,
  output logic [WW-1:0]   out_sel,
  output logic [NTOT-1:0] samp_strobe,
  output logic            cal_valid,
  output logic            sched_start,
  output logic            win_done
);
  logic lane_is_cal;

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    assign samp_strobe[i] = (lane == CW'(i));
  end
  assign samp_strobe[NCH] = (phase == '0);

  for (genvar i = 0; i < NTOT; i++) begin : g_route
    assign cal_route[i] = (win == WW'(i));
  end

  assign lane_is_cal = (win != WW'(NCH)) && (WW'(lane) == win);
  assign out_sel     = lane_is_cal ? WW'(NCH) : WW'(lane);
  assign cal_valid   = |(samp_strobe & cal_route);
  assign sched_start = pos_zero;
  assign win_done    = (tone_in_win == TW'(NCH - 1)) && (phase == PW'(NTOT - 1));
endmodule

// File: rtl/tirot_seq.sv
module tirot_seq #(
  parameter int unsigned NCH = tirot_pkg::TIROT_DEF_CH,
  localparam int unsigned NTOT = NCH + 1,
  localparam int unsigned WW = $clog2(NTOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  output logic [NTOT-1:0] cal_route,
  output logic [WW-1:0]   out_sel,
  output logic [NTOT-1:0] samp_strobe,
  output logic            cal_valid,
  output logic            sched_start,
  output logic            win_done
);
  localparam int unsigned SLEN = tirot_pkg::sched_len(NCH);
  localparam int unsigned CW = (NCH > 2) ? $clog2(NCH) : 1;
  localparam int unsigned PW = $clog2(NTOT);
  localparam int unsigned SW = $clog2(SLEN);

  logic [CW-1:0] lane;
  logic [PW-1:0] phase;
  logic [CW-1:0] tone_in_win;
  logic [WW-1:0] win;
  logic [SW-1:0] pos;
  logic          lane_wrap, phase_wrap, tone_wrap, win_wrap, pos_wrap;

  // Regular-channel lane: position mod NCH.
  tirot_wrap_cnt #(.LIMIT(NCH)) u_lane (
    .clk(clk), .rst_n(rst_n), .step(en), .cnt(lane), .wrap(lane_wrap));

  // Tone phase: position mod (NCH+1).
  tirot_wrap_cnt #(.LIMIT(NTOT)) u_phase (
    .clk(clk), .rst_n(rst_n), .step(en), .cnt(phase), .wrap(phase_wrap));

  // Tone periods inside a calibration window.
  tirot_wrap_cnt #(.LIMIT(NCH)) u_tone (
    .clk(clk), .rst_n(rst_n), .step(phase_wrap), .cnt(tone_in_win), .wrap(tone_wrap));

  // Calibration window index: the channel being calibrated.
  tirot_wrap_cnt #(.LIMIT(NTOT)) u_win (
    .clk(clk), .rst_n(rst_n), .step(tone_wrap), .cnt(win), .wrap(win_wrap));

  // Full schedule position.
  tirot_wrap_cnt #(.LIMIT(SLEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(en), .cnt(pos), .wrap(pos_wrap));

  tirot_decode #(.NCH(NCH)) u_dec (
    .lane(lane), .phase(phase), .tone_in_win(tone_in_win), .win(win),
    .pos_zero(pos == '0),
    .cal_route(cal_route), .out_sel(out_sel), .samp_strobe(samp_strobe),
    .cal_valid(cal_valid), .sched_start(sched_start), .win_done(win_done));

  logic unused_wraps;
  assign unused_wraps = lane_wrap ^ win_wrap ^ pos_wrap;
endmodule

// File: rtl/tirot_seq_chk.sv
module tirot_seq_chk #(
  parameter int unsigned NCH = 4,
  localparam int unsigned NTOT = NCH + 1,
  localparam int unsigned WW = $clog2(NTOT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [NTOT-1:0] cal_route,
  input logic [WW-1:0]   out_sel,
  input logic [NTOT-1:0] samp_strobe,
  input logic            cal_valid,
  input logic            sched_start,
  input logic            win_done
);
  // R3
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cal_route) == 1);

  // R3
  route_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_done && !cal_route[NCH]) |=> (cal_route == ($past(cal_route) << 1)));

  // R2
  sched_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && win_done && cal_route[NCH]) |=> (sched_start && cal_route[0]));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sched_start) |=> !sched_start);

  // R7
  sel_not_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sel <= WW'(NCH)) && !cal_route[out_sel]);

  // R8
  valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid == (|(samp_strobe & cal_route)));

  // R4
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(samp_strobe[NCH-1:0]) == 1);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cal_route) && $stable(out_sel) && $stable(samp_strobe) &&
             $stable(cal_valid) && $stable(sched_start) && $stable(win_done)));
endmodule

bind tirot_seq tirot_seq_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_tirot_seq.sv
`timescale 1ns/1ps
module sim_tirot_seq;
  typedef struct {
    int    pos;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [4:0] cal_route;
  logic [2:0] out_sel;
  logic [4:0] samp_strobe;
  logic       cal_valid, sched_start, win_done;

  int   n_chk = 0;
  int   n_fail = 0;
  int   pos = 0;
  bit   first = 1'b1;
  bit   prev_en = 1'b1;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t it;

  always #2.5 clk = ~clk;

  tirot_seq u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cal_route(cal_route), .out_sel(out_sel),
    .samp_strobe(samp_strobe), .cal_valid(cal_valid), .sched_start(sched_start),
    .win_done(win_done));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compare outputs against the model position.
  always @(negedge clk) begin
    #1;
    if (q.size() > 0) begin
      int w, k, sel, stb;
      it  = q.pop_front();
      w   = it.pos / 20;
      k   = it.pos % 4;
      sel = (w < 4 && k == w) ? 4 : k;
      stb = (1 << k) | ((it.pos % 5 == 0) ? 16 : 0);
      chk({it.tag, " R2 start"},   int'(sched_start), (it.pos == 0) ? 1 : 0);
      chk({it.tag, " R3 route"},   int'(cal_route), 1 << w);
      chk({it.tag, " R4 lanes"},   int'(samp_strobe[3:0]), stb & 15);
      chk({it.tag, " R5 spare"},   int'(samp_strobe[4]), (stb >> 4) & 1);
      chk({it.tag, " R6 sel"},     int'(out_sel), sel);
      chk({it.tag, " R7 notcal"},  (int'(out_sel) == w) ? 1 : 0, 0);
      chk({it.tag, " R8 valid"},   int'(cal_valid), (stb >> w) & 1);
      chk({it.tag, " R9 windone"}, int'(win_done), (it.pos % 20 == 19) ? 1 : 0);
    end
  end

  // Driver: push the expectation for this cycle, then set enable.
  task automatic cycle(input logic e);
    exp_t x;
    @(negedge clk);
    x.pos = pos;
    x.tag = first ? "R1" : (!prev_en ? "R10" : "run");
    q.push_back(x);
    first   = 1'b0;
    prev_en = e;
    en      = e;
    if (e) pos = (pos + 1) % 100;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    pos   = 0;
    first = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    en    = 1'b0;
    do_reset();
    for (int i = 0; i < 230; i++) cycle(1'b1);
    for (int i = 0; i < 60; i++) cycle((i % 3) != 1);
    for (int i = 0; i < 20; i++) cycle(1'b0);
    for (int i = 0; i < 37; i++) cycle(1'b1);
    do_reset();
    for (int i = 0; i < 60; i++) cycle(1'b1);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule